// File: doc/BRIEF.md
# Majority-Gate Ripple Adder

This block adds two unsigned WIDTH-bit operands and a carry-in. Every bit position is assembled only from three-input majority gates and inverters, as a logic-level model of an adder meant for a majority-logic fabric. The carry of each bit comes from a single majority gate. The inverted carry-out of the same bit is fed back into that bit's sum network, so no exclusive-OR gate is needed anywhere. The WIDTH slices form a ripple chain. The final carry leaves the block as the carry-out.

A parameter chooses one of two sum networks. The compact network spends two majority gates per sum bit. The cascaded network spends three majority gates per sum bit and adds one regenerating gate on the carry-out. Both produce identical results for every input. A single register stage captures the sum and the carry-out, so a result appears on the outputs one clock after its operands were presented. The register is cleared by a synchronous active-low reset.

Top module: `maj_ripple_adder`

## Requirements
- R1: On a rising clock edge with rst_n low, sum_o and cout_o become all zero, whatever the operands are.
- R2: With rst_n high, {cout_o, sum_o} after a rising edge equals a_i + b_i + cin_i as sampled at that same edge (one-cycle latency, WIDTH+1-bit unsigned result).
- R3: With SUM_STYLE = SUM_COMPACT (value 0), the result matches the arithmetic sum for every combination of a_i, b_i and cin_i.
- R4: With SUM_STYLE = SUM_CASCADE (value 1), the result matches the arithmetic sum for every input, so it is identical to the compact variant.
- R5: When the least significant operand bits are a_i[0]=0 and b_i[0]=1, the result is still exact; for example 2 + 3 with cin_i=0 gives sum 5 with no carry-out.
- R6: A carry ripples through every position: all-ones plus 1, or all-ones plus zero with cin_i=1, gives sum_o = 0 and cout_o = 1.
- R7: sum_o[0] equals the exclusive-OR of a_i[0], b_i[0] and cin_i from the previous edge.
- R8: If a_i and b_i both have a 1 in the most significant bit (bit WIDTH-1), cout_o is 1; if both have a 0 there, cout_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; operands are sampled and results are registered on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the result register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry out of bit WIDTH-1 |

## Verification
The properties assume that a_i, b_i and cin_i carry known values at every rising edge once reset is released, because each registered result is compared against the operands of the previous edge. The stimulus meets this assumption. It drives operands only on falling edges, holds them at known values during reset, and presents a new operand set on every cycle. The pipeline therefore never sees an unknown value. Both sum variants are driven in parallel with the same operands. Every combination of operands and carry-in is applied at the default width.

// File: rtl/mga_pkg.sv
package mga_pkg;

    // Selects the sum network placed in every bit slice
    typedef enum logic {
        SUM_COMPACT = 1'b0,   // two majority gates per sum bit
        SUM_CASCADE = 1'b1    // three majority gates per sum bit
    } sum_style_e;

endpackage

// File: rtl/mga_maj3.sv
// Three-input majority primitive: true when at least two inputs are true
module mga_maj3 (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic m
);
    assign m = (x & y) | (y & z) | (z & x);
endmodule

// File: rtl/mga_inv.sv
// Inverter primitive
module mga_inv (
    input  logic x,
    output logic y
);
    assign y = ~x;
endmodule

// File: rtl/mga_bit_slice.sv
// One adder position: a carry gate plus a selectable majority sum network.
// ncin is the inverted carry into this slice; dout is the inverted carry
// out of this slice, produced outside and fed back into the sum network.
module mga_bit_slice
    import mga_pkg::*;
#(
    parameter sum_style_e SUM_STYLE = SUM_COMPACT
) (
    input  logic a,
    input  logic b,
    input  logic cin,
    input  logic ncin,
    input  logic dout,
    output logic s,
    output logic cout
);
    // carry: single majority gate
    mga_maj3 u_carry (.x(a), .y(b), .z(cin), .m(cout));

    generate
        if (SUM_STYLE == SUM_COMPACT) begin : g_compact
            logic part;
            mga_maj3 u_part (.x(a),    .y(b),    .z(ncin), .m(part));
            mga_maj3 u_sum  (.x(part), .y(dout), .z(cin),  .m(s));
        end else begin : g_cascade
            logic part;
            logic mid;
            mga_maj3 u_part (.x(a),    .y(b),    .z(ncin), .m(part));
            // carry and its inverse cancel, passing part along one more stage
            mga_maj3 u_mid  (.x(part), .y(cout), .z(dout), .m(mid));
            mga_maj3 u_sum  (.x(mid),  .y(dout), .z(cin),  .m(s));
        end
    endgenerate
endmodule

// File: rtl/mga_ripple_core.sv
// WIDTH slices chained by their carries; inverted carries are shared
// between the slice that produces a carry and the slice that consumes it.
module mga_ripple_core
    import mga_pkg::*;
#(
    parameter int         WIDTH     = 8,
    parameter sum_style_e SUM_STYLE = SUM_COMPACT
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NCARRY = WIDTH + 1;

    logic [NCARRY-1:0] carry;
    logic [NCARRY-1:0] ncarry;

    assign carry[0] = cin;
    mga_inv u_inv_cin (.x(carry[0]), .y(ncarry[0]));

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            mga_bit_slice #(.SUM_STYLE(SUM_STYLE)) u_slice (
                .a    (a[i]),
                .b    (b[i]),
                .cin  (carry[i]),
                .ncin (ncarry[i]),
                .dout (ncarry[i+1]),
                .s    (sum[i]),
                .cout (carry[i+1])
            );
            mga_inv u_inv_carry (.x(carry[i+1]), .y(ncarry[i+1]));
        end

        if (SUM_STYLE == SUM_COMPACT) begin : g_cout_direct
            assign cout = carry[WIDTH];
        end else begin : g_cout_regen
            // restore the carry from its inverse and vote it with both polarities
            logic restored;
            mga_inv  u_inv_restore (.x(ncarry[WIDTH]), .y(restored));
            mga_maj3 u_regen (.x(carry[WIDTH]), .y(restored), .z(ncarry[WIDTH]), .m(cout));
        end
    endgenerate
endmodule

// File: rtl/maj_ripple_adder.sv
module maj_ripple_adder
    import mga_pkg::*;
#(
    parameter int         WIDTH     = 8,
    parameter sum_style_e SUM_STYLE = SUM_COMPACT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
    } result_t;

    logic [WIDTH-1:0] sum_w;
    logic             cout_w;
    result_t          res_d;
    result_t          res_q;

    mga_ripple_core #(.WIDTH(WIDTH), .SUM_STYLE(SUM_STYLE)) u_core (
        .a    (a_i),
        .b    (b_i),
        .cin  (cin_i),
        .sum  (sum_w),
        .cout (cout_w)
    );

    always_comb begin
        res_d.sum  = sum_w;
        res_d.cout = cout_w;
        if (!rst_n) begin
            res_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        res_q <= res_d;
    end

    assign sum_o  = res_q.sum;
    assign cout_o = res_q.cout;
endmodule

// File: rtl/mga_checker.sv
module mga_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o
);
    logic [WIDTH:0] arith_w;
    assign arith_w = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    // R1: the first edge after reset shows a cleared result
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (sum_o == '0 && cout_o == 1'b0));

    // R2, R3, R4: registered result equals last edge's arithmetic sum
    p_sum_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({cout_o, sum_o} == $past(arith_w)));

    // R7: low sum bit is the parity of the low inputs
    p_lsb_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sum_o[0] == $past(a_i[0] ^ b_i[0] ^ cin_i)));

    // R8: both top bits set generates a carry-out
    p_carry_gen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(a_i[WIDTH-1] & b_i[WIDTH-1])) |-> cout_o);

    // R8: both top bits clear kills the carry-out
    p_carry_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(~a_i[WIDTH-1] & ~b_i[WIDTH-1])) |-> !cout_o);
endmodule

bind maj_ripple_adder mga_checker #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/sim_maj_ripple_adder.sv
module sim_maj_ripple_adder;
    import mga_pkg::*;

    localparam int W = 8;
    localparam int SPAN = 1 << W;
    localparam int WATCHDOG_CYCLES = 180000;

    typedef struct {
        logic [W:0] val;
        string      tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '1;
    logic [W-1:0] b = '1;
    logic         cin = 1'b1;
    logic [W-1:0] sum0, sum1;
    logic         cout0, cout1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    maj_ripple_adder #(.WIDTH(W), .SUM_STYLE(SUM_COMPACT)) u0 (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum0), .cout_o(cout0)
    );

    maj_ripple_adder #(.WIDTH(W), .SUM_STYLE(SUM_CASCADE)) u1 (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum1), .cout_o(cout1)
    );

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // driver: present operands on a falling edge and queue the expectation
    task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb,
                         input logic vc, input string tag);
        item_t it;
        @(negedge clk);
        a   = va;
        b   = vb;
        cin = vc;
        it.val = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: sample after each rising edge and compare both variants
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.tag, {cout0, sum0}, it.val);
                check({"R4 ", it.tag}, {cout1, sum1}, it.val);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset clears the result even with all-ones operands
        repeat (2) @(posedge clk);
        #2;
        check("R1 compact reset", {cout0, sum0}, '0);
        check("R1 cascade reset", {cout1, sum1}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: low operand bits a0=0, b0=1
        drive(8'd2, 8'd3, 1'b0, "R5 2+3");
        drive(8'd4, 8'd1, 1'b0, "R5 4+1");
        drive(8'd6, 8'd7, 1'b1, "R5 6+7+1");
        // R6: full-length ripple
        drive('1, 8'd1, 1'b0, "R6 ones+1");
        drive('1, 8'd0, 1'b1, "R6 ones+cin");
        // R7: low sum bit parity
        drive(8'd1, 8'd0, 1'b0, "R7 1+0");
        drive(8'd1, 8'd1, 1'b1, "R7 1+1+1");
        // R8: carry generate and kill at the top bit
        drive(8'h80, 8'h80, 1'b0, "R8 generate");
        drive(8'h7F, 8'h7F, 1'b1, "R8 kill");
        // R2: back-to-back operand sets, one result per cycle
        drive(8'hA5, 8'h5A, 1'b0, "R2 a5+5a");
        drive(8'h00, 8'h00, 1'b0, "R2 zero");
        drive(8'hC3, 8'h3C, 1'b1, "R2 c3+3c+1");

        // R3 (compact) and R4 (cascade): every operand combination
        for (int ia = 0; ia < SPAN; ia++) begin
            for (int ib = 0; ib < SPAN; ib++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    drive(W'(ia), W'(ib), 1'(ic), "R3 exhaustive");
                end
            end
        end

        // let the queue drain, then reset again with live operands (R1)
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        a = 8'hA5;
        b = 8'h7E;
        cin = 1'b1;
        @(posedge clk);
        #2;
        check("R1 compact mid-run reset", {cout0, sum0}, '0);
        check("R1 cascade mid-run reset", {cout1, sum1}, '0);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2: got %0d pending results expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule